// File: doc/BRIEF.md
# Pin Transition Event Detector

This block watches six external control lines of a serial controller and records their transitions as I/O status events. The lines are the receive clock, the transmit clock, the receive and transmit DMA request lines, carrier detect and clear-to-send. Each line has its own enable and its own choice of edge: rising, falling or both. Detection depends only on the level seen at the line. It does not depend on the function the line currently serves.

Every line first passes through a synchroniser. An edge is found by comparing the synchronised level with the level from the previous cycle. When an edge is selected and enabled, it sets a sticky status bit. Software clears that bit by writing a 1 to it. The OR of all status bits drives the I/O status request of the interrupt controller.

Top module: `pin_edge_irq`

## Requirements
- R1: After reset, `status_o` is all zero and `irq_o` is low.
- R2: With edge select 2'b01 (rising) and the enable set, a 0-to-1 change on `pins_i[k]` sets `status_o[k]`. The bit is visible after the third rising clock edge that follows the change, and not before. A 1-to-0 change sets nothing.
- R3: With edge select 2'b10 (falling) and the enable set, a 1-to-0 change on `pins_i[k]` sets `status_o[k]` with the same latency as R2. A 0-to-1 change sets nothing.
- R4: Edge select 2'b11 reacts to both edges. Edge select 2'b00 reacts to neither. The select for line k sits at `edge_sel_i[2k+1:2k]`.
- R5: While `pin_en_i[k]` is low, no transition sets `status_o[k]`, and a bit that is already set stays set.
- R6: A set status bit stays set until software clears it. A pulse on `clr_i[k]` clears `status_o[k]` at the next clock edge. Other bits are not affected.
- R7: If an enabled edge reaches the status register on the same clock edge as a clear of that bit, the bit stays set.
- R8: `irq_o` is high exactly when at least one `status_o` bit is set, in the same cycle, with no added register.
- R9: Line levels already present when reset is released do not produce events. Only later transitions do.
- R10: Each line maps to its own bit, in this order: 0 receive clock, 1 transmit clock, 2 receive DMA request, 3 transmit DMA request, 4 carrier detect, 5 clear-to-send. An event on one line never sets another line's bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pins_i | input | 6 | Raw asynchronous line levels |
| pin_en_i | input | 6 | Per-line event enable |
| edge_sel_i | input | 12 | Per-line edge select, 2 bits per line (01 rise, 10 fall, 11 both, 00 none) |
| clr_i | input | 6 | Write-1-to-clear pulse for status bits |
| status_o | output | 6 | Sticky event bits |
| irq_o | output | 1 | OR of all status bits |

## Verification
An input change made at a falling clock edge passes two synchroniser flops and the previous-level flop, so it reaches `status_o` after the third rising edge. The bench therefore checks the status bit to be still clear after two cycles and set after three. A clear takes effect on the next rising edge and is checked one cycle after it is driven. The collision case drives the clear exactly two cycles after a line change, so that the clear and the detected edge meet at the same register update. All inputs are driven and all outputs are sampled at falling clock edges.

// File: rtl/pin_edge_irq_pkg.sv
package pin_edge_irq_pkg;
  typedef enum logic [1:0] {
    EDGE_NONE = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_BOTH = 2'b11
  } edge_sel_e;

  localparam int unsigned LINE_RXC   = 0;
  localparam int unsigned LINE_TXC   = 1;
  localparam int unsigned LINE_RXREQ = 2;
  localparam int unsigned LINE_TXREQ = 3;
  localparam int unsigned LINE_DCD   = 4;
  localparam int unsigned LINE_CTS   = 5;
endpackage

// File: rtl/pin_edge_irq_sync.sv
module pin_edge_irq_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] stage_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stage_q <= '0;
    else         stage_q <= {stage_q[STAGES-2:0], d_i};
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/pin_edge_irq_det.sv
module pin_edge_irq_det
  import pin_edge_irq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       armed_i,
  input  logic       lvl_i,
  input  logic       en_i,
  input  logic [1:0] sel_i,
  output logic       hit_o
);
  logic prev_q;
  logic rise, fall;
  edge_sel_e sel;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= lvl_i;
  end

  assign sel  = edge_sel_e'(sel_i);
  // prev_q holds no real level until the pipeline has filled
  assign rise = armed_i &  lvl_i & ~prev_q;
  assign fall = armed_i & ~lvl_i &  prev_q;

  always_comb begin
    unique case (sel)
      EDGE_RISE: hit_o = en_i & rise;
      EDGE_FALL: hit_o = en_i & fall;
      EDGE_BOTH: hit_o = en_i & (rise | fall);
      default:   hit_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/pin_edge_irq_status.sv
module pin_edge_irq_status #(
  parameter int unsigned WIDTH = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] hit_i,
  input  logic [WIDTH-1:0] clr_i,
  output logic [WIDTH-1:0] status_o
);
  logic [WIDTH-1:0] status_q;

  // a new edge takes priority over a clear in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) status_q <= '0;
    else         status_q <= (status_q & ~clr_i) | hit_i;
  end

  assign status_o = status_q;

  p_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((status_q & ~clr_i) != '0) |=>
      ((status_q & $past(status_q & ~clr_i)) == $past(status_q & ~clr_i)));

  p_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((clr_i & ~hit_i) != '0) |=> ((status_q & $past(clr_i & ~hit_i)) == '0));

  p_collision_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((clr_i & hit_i) != '0) |=> ((status_q & $past(clr_i & hit_i)) == $past(clr_i & hit_i)));

  p_set_by_hit_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((status_q & ~$past(status_q) & ~$past(hit_i)) == '0));
endmodule

// File: rtl/pin_edge_irq.sv
module pin_edge_irq
  import pin_edge_irq_pkg::*;
#(
  parameter int unsigned NUM_PINS    = 6,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [NUM_PINS-1:0]   pins_i,
  input  logic [NUM_PINS-1:0]   pin_en_i,
  input  logic [2*NUM_PINS-1:0] edge_sel_i,
  input  logic [NUM_PINS-1:0]   clr_i,
  output logic [NUM_PINS-1:0]   status_o,
  output logic                  irq_o
);
  localparam int unsigned ARM_CNT = SYNC_STAGES + 1;
  localparam int unsigned CNT_W   = $clog2(ARM_CNT + 1);
  localparam logic [CNT_W-1:0] ARM_VAL = CNT_W'(ARM_CNT);

  logic [CNT_W-1:0]    arm_cnt_q;
  logic                armed;
  logic [NUM_PINS-1:0] lvl, hit;

  // block events until synchroniser and previous-level flop hold real samples
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             arm_cnt_q <= '0;
    else if (!armed)         arm_cnt_q <= arm_cnt_q + 1'b1;
  end
  assign armed = (arm_cnt_q == ARM_VAL);

  for (genvar k = 0; k < NUM_PINS; k++) begin : g_line
    pin_edge_irq_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .d_i    (pins_i[k]),
      .q_o    (lvl[k])
    );
    pin_edge_irq_det u_det (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .armed_i (armed),
      .lvl_i   (lvl[k]),
      .en_i    (pin_en_i[k]),
      .sel_i   (edge_sel_i[2*k +: 2]),
      .hit_o   (hit[k])
    );
  end

  pin_edge_irq_status #(.WIDTH(NUM_PINS)) u_status (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .hit_i    (hit),
    .clr_i    (clr_i),
    .status_o (status_o)
  );

  assign irq_o = |status_o;

  p_disabled_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((status_o & ~$past(status_o) & ~$past(pin_en_i)) == '0));

  p_no_early_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !armed |=> (status_o == '0));
endmodule

// File: tb/pin_edge_irq_bench.sv
module pin_edge_irq_bench;
  localparam int N = 6;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] pins = '0, en = '0, clr = '0;
  logic [2*N-1:0] sel = '0;
  logic [N-1:0] status;
  logic         irq;
  int errors = 0, checks = 0;

  always #2 clk = ~clk;

  pin_edge_irq u_pin_edge_irq (
    .clk_i(clk), .rst_ni(rst_n), .pins_i(pins), .pin_en_i(en),
    .edge_sel_i(sel), .clr_i(clr), .status_o(status), .irq_o(irq)
  );

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_sel(input int k, input logic [1:0] s);
    sel[2*k +: 2] = s;
  endtask

  task automatic clear_all();
    clr = '1; cyc(1); clr = '0; cyc(1);
  endtask

  task automatic t_reset();
    pins = '1; en = '1; sel = '1;
    rst_n = 1'b0; cyc(3); rst_n = 1'b1;
    chk({2'b0, status}, 8'h00, "R1 status after reset");
    chk({7'b0, irq}, 8'h00, "R1 irq after reset");
    cyc(10);
    chk({2'b0, status}, 8'h00, "R9 no event from reset level");
    pins = '0; cyc(3);
    chk({2'b0, status}, 8'h3f, "R9 later falling edges detected");
    clear_all();
  endtask

  task automatic t_rise();
    sel = '0; en = '1; set_sel(0, 2'b01);
    pins[0] = 1'b1; cyc(2);
    chk({2'b0, status}, 8'h00, "R2 not before third edge");
    cyc(1);
    chk({2'b0, status}, 8'h01, "R2 rising sets bit0");
    chk({7'b0, irq}, 8'h01, "R8 irq with bit set");
    clear_all();
    pins[0] = 1'b0; cyc(4);
    chk({2'b0, status}, 8'h00, "R2 falling ignored under rise select");
  endtask

  task automatic t_fall();
    sel = '0; set_sel(3, 2'b10);
    pins[3] = 1'b1; cyc(4);
    chk({2'b0, status}, 8'h00, "R3 rising ignored under fall select");
    pins[3] = 1'b0; cyc(3);
    chk({2'b0, status}, 8'h08, "R3 falling sets bit3 only");
    clear_all();
  endtask

  task automatic t_both_none();
    sel = '0; set_sel(4, 2'b11); set_sel(5, 2'b00);
    pins[5:4] = 2'b11; cyc(3);
    chk({2'b0, status}, 8'h10, "R4 both: rise on bit4, none on bit5");
    clear_all();
    pins[5:4] = 2'b00; cyc(3);
    chk({2'b0, status}, 8'h10, "R4 both: fall on bit4, none on bit5");
    clear_all();
  endtask

  task automatic t_disable();
    sel = '1; en = '1;
    pins[1] = 1'b1; cyc(3);
    chk({2'b0, status}, 8'h02, "R10 only bit1 set by line1");
    en[1] = 1'b0; en[2] = 1'b0;
    pins[1] = 1'b0; pins[2] = 1'b1; cyc(4);
    chk({2'b0, status}, 8'h02, "R5 disabled: no new event, old bit kept");
    pins[2] = 1'b0; cyc(4);
    en = '1;
    clear_all();
  endtask

  task automatic t_clear();
    sel = '1; en = '1;
    pins[3:2] = 2'b11; cyc(3);
    chk({2'b0, status}, 8'h0c, "R6 bits 2,3 set");
    cyc(5);
    chk({2'b0, status}, 8'h0c, "R6 bits stay sticky");
    clr = 6'b000100; cyc(1); clr = '0;
    chk({2'b0, status}, 8'h08, "R6 clear bit2 only");
    chk({7'b0, irq}, 8'h01, "R8 irq still high");
    clr = 6'b001000; cyc(1); clr = '0;
    chk({7'b0, irq}, 8'h00, "R8 irq low when all clear");
    pins[3:2] = 2'b00; cyc(4);
    clear_all();
  endtask

  task automatic t_collision();
    sel = '1; en = '1;
    pins[5] = 1'b1; cyc(3);
    chk({2'b0, status}, 8'h20, "R7 bit5 set before collision");
    pins[5] = 1'b0; cyc(2);
    clr = 6'b100000; cyc(1); clr = '0;
    chk({2'b0, status}, 8'h20, "R7 edge wins over clear");
    clr = 6'b100000; cyc(1); clr = '0;
    chk({2'b0, status}, 8'h00, "R6 clear without edge");
  endtask

  initial begin
    cyc(1);
    t_reset();
    t_rise();
    t_fall();
    t_both_none();
    t_disable();
    t_clear();
    t_collision();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule